// File: doc/BRIEF.md
# Packet Round-Robin Merge

The block merges several input ports onto a single output stream and gives turns by whole packets rather than by single words. Every port presents a data word and a valid bit each cycle. A packet is a run of valid words from one port and ends with the word whose top bit is set. While a packet is in progress, only its port is served. When the closing word has been taken, the next port in cyclic order becomes the preferred one. The block has no buffering and no backpressure. A port that is not served in a cycle simply loses that word, so upstream logic presents words only when it knows the port is being served.

When no packet is open and the preferred port has nothing to send, the block searches forward from that port, wrapping past the last index, and serves the first port that has a valid word. That word is taken in the same cycle, so no bubble is lost. Each taken word leaves the block one clock later on a registered output together with a registered valid bit.

Top module: `pkt_rr_mux`

## Requirements
- R1: The port count `N_PORTS` (default 4) and word width `DATA_W` (default 12) are parameters. Port p drives bits `[p*DATA_W +: DATA_W]` of `in_data` and bit p of `in_valid`.
- R2: A taken word whose most significant bit is 1 closes the packet of its port. A packet may be a single word long.
- R3: After a closing word from port p, the preferred port becomes p+1, and after port N_PORTS-1 it becomes port 0.
- R4: A word taken in cycle t appears on `out_data`, with `out_valid` high, at the clock edge that ends cycle t, and it is held there for one cycle.
- R5: Words on ports other than the served one are ignored, and so is any port whose valid bit is low. None of them reach the output.
- R6: When no packet is open and the preferred port is not valid, the first valid port found by searching forward cyclically from the preferred port is served in that same cycle.
- R7: Once a packet is open, its port alone is served until the closing word. If its valid bit drops between words, no word is taken, even when other ports are valid.
- R8: `out_data` is zero in every cycle in which `out_valid` is low.
- R9: A synchronous active-high `rst` makes port 0 preferred, closes any open packet, and drives `out_valid` low and `out_data` to zero.
- R10: When no packet is open and no port is valid, nothing is taken and the preferred port stays the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | N_PORTS | Per-port word valid |
| in_data | input | N_PORTS*DATA_W | Per-port words, port p at bits [p*DATA_W +: DATA_W] |
| out_valid | output | 1 | Registered valid of the merged stream |
| out_data | output | DATA_W | Registered merged word, zero when not valid |

## Verification
The hardest case to reach from the ports is a packet that stalls part way through while other ports keep offering words. Correct behaviour there is an empty output, not a switch to another port. The stimulus opens a packet, then clears only the valid bit of the port that owns it and keeps every other port valid before letting the packet finish. Reaching the idle search that wraps past the highest index takes a second step. The stimulus first leaves the preferred port at the last index, then makes only a lower-numbered port valid. Reset is also applied in the middle of an open packet, to show that the next turn starts again at port 0.

// File: rtl/pkt_rr_pkg.sv
package pkt_rr_pkg;

  // Index width for a port count; at least one bit.
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rrpm_picker.sv
module rrpm_picker #(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic [N_PORTS-1:0] valid,
  input  logic [IDX_W-1:0]   pref,
  input  logic               open_pkt,
  output logic [IDX_W-1:0]   sel,
  output logic               hit
);

  // pref + k, folded back into 0..N_PORTS-1
  function automatic logic [IDX_W-1:0] step_from(input logic [IDX_W-1:0] base,
                                                 input int unsigned k);
    int unsigned s;
    s = int'(base) + k;
    if (s >= N_PORTS) s = s - N_PORTS;
    return IDX_W'(s);
  endfunction

  always_comb begin
    sel = pref;
    hit = 1'b0;
    if (open_pkt) begin
      hit = valid[pref];
    end else begin
      for (int unsigned k = 0; k < N_PORTS; k++) begin
        if (!hit && valid[step_from(pref, k)]) begin
          sel = step_from(pref, k);
          hit = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rrpm_sched.sv
module rrpm_sched #(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             closing,
  input  logic [IDX_W-1:0] sel,
  output logic [IDX_W-1:0] pref,
  output logic             open_pkt
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_PORTS - 1);

  function automatic logic [IDX_W-1:0] after(input logic [IDX_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pref     <= '0;
      open_pkt <= 1'b0;
    end else if (take) begin
      if (closing) begin
        pref     <= after(sel);
        open_pkt <= 1'b0;
      end else begin
        pref     <= sel;
        open_pkt <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rrpm_outreg.sv
module rrpm_outreg #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [DATA_W-1:0] word,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else begin
      q_valid <= take;
      q_data  <= take ? word : '0;
    end
  end

endmodule

// File: rtl/pkt_rr_mux.sv
module pkt_rr_mux #(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned DATA_W  = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_PORTS-1:0]          in_valid,
  input  logic [N_PORTS*DATA_W-1:0]   in_data,
  output logic                        out_valid,
  output logic [DATA_W-1:0]           out_data
);

  localparam int unsigned IDX_W = pkt_rr_pkg::idx_bits(N_PORTS);

  logic [DATA_W-1:0] words [N_PORTS];
  logic [IDX_W-1:0]  grant;
  logic              busy;
  logic [IDX_W-1:0]  sel_port;
  logic              accept;
  logic [DATA_W-1:0] sel_word;
  logic              eop_seen;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_unpack
    assign words[p] = in_data[p*DATA_W +: DATA_W];
  end

  rrpm_picker #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) picker_i (
    .valid    (in_valid),
    .pref     (grant),
    .open_pkt (busy),
    .sel      (sel_port),
    .hit      (accept)
  );

  assign sel_word = words[sel_port];
  assign eop_seen = accept & sel_word[DATA_W-1];

  rrpm_sched #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) sched_i (
    .clk      (clk),
    .rst      (rst),
    .take     (accept),
    .closing  (eop_seen),
    .sel      (sel_port),
    .pref     (grant),
    .open_pkt (busy)
  );

  rrpm_outreg #(.DATA_W(DATA_W)) outreg_i (
    .clk     (clk),
    .rst     (rst),
    .take    (accept),
    .word    (sel_word),
    .q_valid (out_valid),
    .q_data  (out_data)
  );

endmodule

// File: rtl/pkt_rr_mux_chk.sv
module pkt_rr_mux_chk #(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned IDX_W   = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic [N_PORTS-1:0]        in_valid,
  input logic [N_PORTS*DATA_W-1:0] in_data,
  input logic                      out_valid,
  input logic [DATA_W-1:0]         out_data,
  input logic [IDX_W-1:0]          grant,
  input logic                      busy,
  input logic [IDX_W-1:0]          sel_port,
  input logic                      accept,
  input logic                      eop_seen
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(N_PORTS - 1);

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_data == '0);  // R8

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid && out_data == $past(in_data[sel_port*DATA_W +: DATA_W]));  // R4

  AST_NO_TAKE_NO_OUT: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !out_valid);  // R5

  AST_TAKE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    accept |-> in_valid[sel_port]);  // R5

  AST_LOCKED_PORT: assert property (@(posedge clk) disable iff (rst)
    busy |-> sel_port == grant);  // R7

  AST_OPEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (accept && !eop_seen) |=> busy && grant == $past(sel_port));  // R2

  AST_CLOSE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    eop_seen |=> !busy &&
      grant == (($past(sel_port) == TOP_IDX) ? '0 : $past(sel_port) + 1'b1));  // R3

  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!busy && in_valid == '0) |=> !busy && $stable(grant));  // R10

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> grant == '0 && !busy && !out_valid && out_data == '0);  // R9

endmodule

bind pkt_rr_mux pkt_rr_mux_chk #(
  .N_PORTS (N_PORTS),
  .DATA_W  (DATA_W),
  .IDX_W   (IDX_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .grant     (grant),
  .busy      (busy),
  .sel_port  (sel_port),
  .accept    (accept),
  .eop_seen  (eop_seen)
);

// File: tb/pkt_rr_mux_tb_top.sv
module pkt_rr_mux_tb_top;

  localparam int N = 4;
  localparam int W = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N-1:0]     in_valid = '0;
  logic [N*W-1:0]   in_data  = '0;
  logic             out_valid;
  logic [W-1:0]     out_data;

  always #5 clk = ~clk;

  pkt_rr_mux #(.N_PORTS(N), .DATA_W(W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  typedef struct {
    logic         v;
    logic [W-1:0] d;
    string        tag;
    int           stamp;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc    = 0;
  bit   done   = 0;

  // bench-side expectation state
  int   m_pref = 0;
  bit   m_open = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // word layout used by the stimulus: {last, port[2:0], seq[7:0]}
  function automatic logic [W-1:0] mk(input int p, input int s, input bit last);
    return {last, 3'(p), 8'(s)};
  endfunction

  function automatic logic [N*W-1:0] pack(input int s, input logic [N-1:0] lastm);
    logic [N*W-1:0] r;
    for (int p = 0; p < N; p++) r[p*W +: W] = mk(p, s, lastm[p]);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic av, input logic [W-1:0] ad,
                       input logic ev, input logic [W-1:0] ed);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got valid=%0b data=%h expected valid=%0b data=%h",
               tag, av, ad, ev, ed);
    end
  endtask

  // driver: apply one cycle of inputs and queue what should come out
  task automatic step(input logic [N-1:0] v, input logic [N*W-1:0] d, input string tag);
    exp_t e;
    int   pick;
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    pick = -1;
    if (m_open) begin
      if (v[m_pref]) pick = m_pref;
    end else begin
      for (int off = 0; off < N; off++)
        if (pick < 0 && v[(m_pref + off) % N]) pick = (m_pref + off) % N;
    end
    e.tag = tag;
    e.stamp = cyc;
    if (pick >= 0) begin
      e.v = 1'b1;
      e.d = d[pick*W +: W];
      if (e.d[W-1]) begin
        m_pref = (pick + 1) % N;
        m_open = 0;
      end else begin
        m_pref = pick;
        m_open = 1;
      end
    end else begin
      e.v = 1'b0;
      e.d = '0;
    end
    q.push_back(e);
  endtask

  // monitor: compare each output beat with the oldest queued item
  always @(negedge clk) begin
    if (!rst && q.size() > 0 && q[0].stamp < cyc) begin
      exp_t e;
      e = q.pop_front();
      check(out_valid === e.v && out_data === e.d, e.tag,
            out_valid, out_data, e.v, e.d);
    end
  end

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    in_valid = '1;
    in_data = pack(8'hEE, '0);
    repeat (2) @(negedge clk);
    check(out_valid === 1'b0 && out_data === '0, tag, out_valid, out_data, 1'b0, '0);
    q.delete();
    m_pref = 0;
    m_open = 0;
    rst = 1'b0;
    in_valid = '0;
  endtask

  initial begin
    do_reset("R9 initial reset");

    // R1 R2 R3 R4: every port busy, 3-word packets, order 0,1,2,3 then wrap to 0
    for (int i = 0; i < 15; i++)
      step('1, pack(i, (i % 3 == 2) ? '1 : '0), "R3 cyclic packets");

    // R2: one-word packets back to back
    for (int i = 0; i < 6; i++)
      step('1, pack(8'h40 + i, '1), "R2 single-word packets");

    // R10 R8: nothing valid, output stays low and zero
    for (int i = 0; i < 3; i++)
      step('0, pack(8'h50 + i, '1), "R10 idle");

    // R6: only port 2 offers data, search skips to it
    for (int i = 0; i < 4; i++)
      step(4'b0100, pack(8'h60 + i, (i % 2 == 1) ? '1 : '0), "R6 skip to port 2");
    // preferred port is now 3; only port 1 valid, search wraps 3,0,1
    for (int i = 0; i < 2; i++)
      step(4'b0010, pack(8'h70 + i, (i == 1) ? '1 : '0), "R6 wrap search");

    // R7 R5: open a packet, then drop only its valid while others stay valid
    step('1, pack(8'h80, '0), "R7 open packet");
    begin
      logic [N-1:0] others;
      others = ~(N'(1) << m_pref);
      for (int i = 0; i < 3; i++)
        step(others, pack(8'h81 + i, '1), "R7 stall ignores others");
    end
    step('1, pack(8'h90, '0), "R5 only owner served");
    step('1, pack(8'h91, '1), "R5 owner closes");

    // R8 gap after traffic
    step('0, '0, "R8 zero when idle");

    // R9: reset while a packet is open, next turn starts at port 0
    step(4'b0100, pack(8'hA0, '0), "R9 open before reset");
    do_reset("R9 reset mid-packet");
    step('1, pack(8'hB0, '1), "R9 restart at port 0");
    step('1, pack(8'hB1, '1), "R1 port 1 lane after restart");
    step('0, '0, "R8 drain");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R4: %0d beats never compared, expected 0", q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule